// File: doc/BRIEF.md
# Oversampled SPI Target Port

This block is the target (slave) end of a four-wire SPI link. It is clocked by the system clock and treats the serial clock, the data-in line and the active-low select as ordinary asynchronous inputs. Each one passes through a two-flop synchronizer, and serial-clock transitions are found by comparing successive synchronized samples. For that reason the serial clock must run at no more than a quarter of the system clock rate. The clock polarity and phase are set by two configuration inputs, so all four modes are available. The word length is a parameter.

When the select goes low, a frame begins. The port loads the parallel transmit word and exchanges it, most significant bit first, for the word the controller shifts in. The received word appears on a parallel output together with a one-cycle valid strobe. The port drives its data-out line only while it is selected. The output-enable is low otherwise.

In chain mode the port acts as one stage of a daisy chain: after the first word, it shifts out the bits it has just received. In strict mode a frame is accepted only when it carries exactly one word of clocks. A frame with too many clocks raises an error pulse instead of a valid strobe. In lenient mode the surplus clocks have no effect.

Top module: `spi_target_port`

## Requirements
- R1: While the synchronized select is high, `miso_oe` is low, and serial-clock and data-in activity changes neither the outputs nor the frame state.
- R2: A falling select edge starts a new frame and clears the bit count, so an aborted earlier frame leaves no trace in the next one.
- R3: The mode number is {`cfg_cpol`,`cfg_cpha`}. The idle level of the serial clock equals `cfg_cpol`. With `cfg_cpha`=0 data is sampled on the edge that leaves the idle level and changed on the edge that returns to it; with `cfg_cpha`=1 the two roles are swapped.
- R4: Bits travel most significant first in both directions. After W clocks, `rx_word` holds the W bits received, with the first bit in bit W-1, and the controller has received `tx_word` (sampled at the select falling edge).
- R5: With `cfg_chain`=1, each bit received in a frame is driven out W clocks later. `rx_valid` pulses after every completed group of W clocks, and `cfg_strict` is ignored.
- R6: With `cfg_chain`=0 and `cfg_strict`=0, `rx_valid` pulses when the W-th bit is sampled. Later clocks in the same frame are ignored and `miso_out` holds the last transmitted bit, which is `tx_word[0]`.
- R7: With `cfg_chain`=0 and `cfg_strict`=1, `rx_valid` pulses only when the select rises after exactly W clocks. A frame with more than W clocks gives a one-cycle `frame_err` pulse at the select rise and no strobe. A frame with fewer than W clocks gives neither.
- R8: With `cfg_cpha`=0, `tx_word[W-1]` is on `miso_out` as soon as the port registers the select assertion, before the first serial-clock edge.
- R9: Every output reacts three system clocks after the input change that causes it. In particular, `miso_oe` equals the inverted select from three cycles earlier.
- R10: `rx_valid` and `frame_err` are single-cycle pulses and never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial-clock idle level |
| cfg_cpha | input | 1 | 0: sample on the leading edge, 1: sample on the trailing edge |
| cfg_chain | input | 1 | Daisy-chain pass-through enable |
| cfg_strict | input | 1 | Reject frames with too many clocks |
| tx_word | input | W | Word to send, loaded at frame start |
| sclk_in | input | 1 | Serial clock from the controller |
| mosi_in | input | 1 | Serial data from the controller |
| sel_n_in | input | 1 | Active-low select |
| miso_out | output | 1 | Serial data to the controller |
| miso_oe | output | 1 | Output enable for miso_out |
| rx_word | output | W | Last accepted received word |
| rx_valid | output | 1 | One-cycle strobe: rx_word updated |
| frame_err | output | 1 | One-cycle strobe: strict frame rejected |

## Verification
Each pin change is captured by the two synchronizer flops and then acted on by one register stage. Every output therefore moves at the third rising edge after the change: the data-out bit after a shift edge, the valid strobe after the W-th sample edge or after the select rise, the error pulse, and the enable. The reference model in the bench delays the pins by the same two stages, applies the protocol rules to those delayed values at each rising edge, and compares the outputs at every falling edge. The controller model in the bench keeps each serial-clock half period at four system clocks, so it always samples the data-out line at least one cycle after that line has settled.

// File: rtl/spi_tp_pkg.sv
package spi_tp_pkg;

  // Per-cycle events decoded from the synchronized serial lines.
  typedef struct packed {
    logic start;   // select just asserted
    logic stop;    // select just released
    logic smp;     // data sample edge inside a frame
    logic shf;     // data change edge inside a frame
  } spi_evt_t;

endpackage

// File: rtl/spi_tp_sync.sv
module spi_tp_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/spi_tp_edge.sv
module spi_tp_edge
  import spi_tp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     s_sclk,
  input  logic     s_sel_n,
  input  logic     cpol,
  input  logic     cpha,
  output spi_evt_t evt
);

  logic p_sclk;
  logic p_sel_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_sclk  <= 1'b0;
      p_sel_n <= 1'b1;
    end else begin
      p_sclk  <= s_sclk;
      p_sel_n <= s_sel_n;
    end
  end

  logic toggled, leading, trailing, in_frame;

  always_comb begin
    toggled  = s_sclk ^ p_sclk;
    leading  = toggled & (s_sclk != cpol);
    trailing = toggled & (s_sclk == cpol);
    in_frame = ~s_sel_n & ~p_sel_n;
    evt.start = p_sel_n & ~s_sel_n;
    evt.stop  = ~p_sel_n & s_sel_n;
    evt.smp   = in_frame & (cpha ? trailing : leading);
    evt.shf   = in_frame & (cpha ? leading : trailing);
  end

endmodule

// File: rtl/spi_tp_shifter.sv
module spi_tp_shifter
  import spi_tp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  spi_evt_t     evt,
  input  logic         s_mosi,
  input  logic         cpha,
  input  logic         chain,
  input  logic         strict,
  input  logic [W-1:0] tx_word,
  output logic         miso_q,
  output logic [W-1:0] rx_word,
  output logic         rx_valid,
  output logic         frame_err
);

  localparam int CW = $clog2(W + 2);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] OVER = CW'(W + 1);

  logic [W-1:0]  sr;      // outgoing bits, received bits enter at bit 0
  logic [W-1:0]  rx_sr;   // received word assembly
  logic [CW-1:0] cnt;     // samples taken in the current word

  logic open_word;
  assign open_word = chain | (cnt < FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr        <= '0;
      rx_sr     <= '0;
      cnt       <= '0;
      miso_q    <= 1'b0;
      rx_word   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      if (evt.start) begin
        cnt    <= '0;
        miso_q <= tx_word[W-1];
        sr     <= cpha ? tx_word : {tx_word[W-2:0], 1'b0};
      end else begin
        if (evt.smp && open_word) begin
          sr[0] <= s_mosi;
          rx_sr <= {rx_sr[W-2:0], s_mosi};
          if (cnt == LAST) begin
            cnt <= chain ? '0 : FULL;
            if (chain || !strict) begin
              rx_valid <= 1'b1;
              rx_word  <= {rx_sr[W-2:0], s_mosi};
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (evt.smp && cnt == FULL) begin
          cnt <= OVER;
        end
        if (evt.shf && open_word) begin
          miso_q <= sr[W-1];
          sr     <= {sr[W-2:0], 1'b0};
        end
        if (evt.stop && strict && !chain) begin
          if (cnt == FULL) begin
            rx_valid <= 1'b1;
            rx_word  <= rx_sr;
          end else if (cnt == OVER) begin
            frame_err <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
  import spi_tp_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_cpol,
  input  logic         cfg_cpha,
  input  logic         cfg_chain,
  input  logic         cfg_strict,
  input  logic [W-1:0] tx_word,
  input  logic         sclk_in,
  input  logic         mosi_in,
  input  logic         sel_n_in,
  output logic         miso_out,
  output logic         miso_oe,
  output logic [W-1:0] rx_word,
  output logic         rx_valid,
  output logic         frame_err
);

  logic [2:0] pins_s;
  logic       s_sel_n, s_sclk, s_mosi;
  spi_evt_t   evt;

  spi_tp_sync #(.N(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sel_n_in, sclk_in, mosi_in}),
    .q   (pins_s)
  );

  assign {s_sel_n, s_sclk, s_mosi} = pins_s;

  spi_tp_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .s_sclk  (s_sclk),
    .s_sel_n (s_sel_n),
    .cpol    (cfg_cpol),
    .cpha    (cfg_cpha),
    .evt     (evt)
  );

  spi_tp_shifter #(.W(W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .s_mosi    (s_mosi),
    .cpha      (cfg_cpha),
    .chain     (cfg_chain),
    .strict    (cfg_strict),
    .tx_word   (tx_word),
    .miso_q    (miso_out),
    .rx_word   (rx_word),
    .rx_valid  (rx_valid),
    .frame_err (frame_err)
  );

  always_ff @(posedge clk) begin
    if (rst) miso_oe <= 1'b0;
    else     miso_oe <= ~s_sel_n;
  end

endmodule

// File: rtl/spi_tp_checker.sv
module spi_tp_checker (
  input logic clk,
  input logic rst,
  input logic sel_n_in,
  input logic cfg_chain,
  input logic cfg_strict,
  input logic miso_oe,
  input logic rx_valid,
  input logic frame_err
);

  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  // R9: the enable follows the select pin after three cycles
  a_r9_oe_follow: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (miso_oe == !$past(sel_n_in, 3)));

  // R1: no strobe while the port has been deselected for two cycles
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!miso_oe && !$past(miso_oe)) |-> (!rx_valid && !frame_err));

  // R10: one-cycle strobes
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  // R7: errors only in strict unchained mode, at frame end, never with a strobe
  a_r7_err_strict: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> (cfg_strict && !cfg_chain && !rx_valid && !miso_oe));

  // R7: strict strobe only at the select rise
  a_r7_strobe_at_end: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_strict && !cfg_chain) |-> !miso_oe);

endmodule

bind spi_target_port spi_tp_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_n_in   (sel_n_in),
  .cfg_chain  (cfg_chain),
  .cfg_strict (cfg_strict),
  .miso_oe    (miso_oe),
  .rx_valid   (rx_valid),
  .frame_err  (frame_err)
);

// File: tb/sim_spi_target_port.sv
`timescale 1ns/1ps
module sim_spi_target_port;

  localparam int W  = 8;
  localparam int HP = 4;   // serial half period in system clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_chain = 0, cfg_strict = 0;
  logic [W-1:0] tx_word = '0;
  logic sclk_in = 0, mosi_in = 0, sel_n_in = 1;
  logic miso_out, miso_oe, rx_valid, frame_err;
  logic [W-1:0] rx_word;

  int checks = 0;
  int errors = 0;
  int nvalid = 0;
  int nerr   = 0;
  logic [W-1:0] last_word;

  always #4 clk = ~clk;

  spi_target_port #(.W(W)) u0 (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_chain(cfg_chain), .cfg_strict(cfg_strict), .tx_word(tx_word),
    .sclk_in(sclk_in), .mosi_in(mosi_in), .sel_n_in(sel_n_in),
    .miso_out(miso_out), .miso_oe(miso_oe), .rx_word(rx_word),
    .rx_valid(rx_valid), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model: pins seen through two delay stages
  logic [2:0] d1 = 3'b100, d2 = 3'b100, dp = 3'b100;  // {sel_n, sclk, mosi}
  bit outq[$];
  int m_cnt = 0;
  logic [W-1:0] m_rx = '0;
  logic e_oe = 0, e_miso = 0, e_valid = 0, e_err = 0;
  logic [W-1:0] e_word = '0;

  always @(posedge clk) begin
    if (rst) begin
      d1 = 3'b100; d2 = 3'b100; dp = 3'b100;
      e_oe = 0; e_miso = 0; e_valid = 0; e_err = 0; e_word = '0;
      m_cnt = 0; outq.delete();
    end else begin
      logic fall, rise, inf, tog, lead, smp, shf;
      fall = dp[2] & ~d2[2];
      rise = ~dp[2] & d2[2];
      inf  = ~dp[2] & ~d2[2];
      tog  = d2[1] ^ dp[1];
      lead = tog & (d2[1] != cfg_cpol);
      smp  = inf & tog & (cfg_cpha ? !lead : lead);
      shf  = inf & tog & (cfg_cpha ? lead : !lead);
      e_valid = 0; e_err = 0;
      e_oe = ~d2[2];
      if (fall) begin
        m_cnt = 0;
        outq.delete();
        for (int i = W-1; i >= 0; i--) outq.push_back(tx_word[i]);
        if (cfg_cpha) e_miso = outq[0];
        else          e_miso = outq.pop_front();
      end else begin
        if (smp) begin
          if (cfg_chain || m_cnt < W) begin
            outq.push_back(d2[0]);
            m_rx = {m_rx[W-2:0], d2[0]};
            m_cnt++;
            if (m_cnt == W) begin
              if (cfg_chain || !cfg_strict) begin e_valid = 1; e_word = m_rx; end
              if (cfg_chain) m_cnt = 0;
            end
          end else if (m_cnt == W) m_cnt = W + 1;
        end
        if (shf && (cfg_chain || m_cnt < W))
          e_miso = (outq.size() > 0) ? outq.pop_front() : 1'b0;
        if (rise && cfg_strict && !cfg_chain) begin
          if (m_cnt == W) begin e_valid = 1; e_word = m_rx; end
          else if (m_cnt > W) e_err = 1;
        end
      end
      dp = d2; d2 = d1; d1 = {sel_n_in, sclk_in, mosi_in};
    end
  end

  // ---------------- compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(miso_oe == e_oe, "R9", "oe vs model", miso_oe, e_oe);
      if (e_oe) chk(miso_out == e_miso, "R3", "miso vs model", miso_out, e_miso);
      chk(rx_valid == e_valid, "R10", "valid vs model", rx_valid, e_valid);
      if (e_valid) chk(rx_word == e_word, "R4", "word vs model", rx_word, e_word);
      chk(frame_err == e_err, "R7", "err vs model", frame_err, e_err);
      if (rx_valid) begin nvalid++; last_word = rx_word; end
      if (frame_err) nerr++;
    end
  end

  // ---------------- controller side
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int n, input logic [31:0] mv, output logic [31:0] mr);
    mr = '0;
    sclk_in = cfg_cpol;
    cyc(2);
    sel_n_in = 0;
    cyc(6);
    if (!cfg_cpha) chk(miso_oe && miso_out == tx_word[W-1], "R8",
                       "first bit before clock", {miso_oe, miso_out}, {1'b1, tx_word[W-1]});
    for (int i = 0; i < n; i++) begin
      if (!cfg_cpha) begin
        mosi_in = mv[31-i];
        cyc(HP);
        mr = {mr[30:0], miso_out};
        sclk_in = ~cfg_cpol;
        cyc(HP);
        sclk_in = cfg_cpol;
      end else begin
        sclk_in = ~cfg_cpol;
        mosi_in = mv[31-i];
        cyc(HP);
        mr = {mr[30:0], miso_out};
        sclk_in = cfg_cpol;
        cyc(HP);
      end
    end
    cyc(HP);
    sel_n_in = 1;
    cyc(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] mr;
    int v0, e0;
    cyc(4);
    rst = 0;
    cyc(1);
    // reset state
    chk(!miso_oe && !rx_valid && !frame_err && rx_word == '0, "R1", "reset state",
        {miso_oe, rx_valid, frame_err}, 0);

    // R3 R4: all four modes, lenient, plain word exchange
    for (int m = 0; m < 4; m++) begin
      logic [W-1:0] sent;
      cfg_cpol = m[1]; cfg_cpha = m[0];
      tx_word = 8'hA5 ^ 8'(m * 8'h17);
      sent = 8'h3C + 8'(m * 8'h29);
      v0 = nvalid;
      frame(W, {sent, 24'h0}, mr);
      chk(mr[7:0] == tx_word, "R4", "controller got tx word", mr[7:0], tx_word);
      chk(last_word == sent && nvalid == v0 + 1, "R3", "mode word received", last_word, sent);
    end

    // R1: activity while deselected is ignored
    cfg_cpol = 0; cfg_cpha = 0;
    v0 = nvalid;
    for (int i = 0; i < 12; i++) begin
      sclk_in = ~sclk_in; mosi_in = i[0];
      cyc(HP);
      chk(!miso_oe, "R1", "oe while deselected", miso_oe, 0);
    end
    sclk_in = 0;
    cyc(6);
    chk(nvalid == v0, "R1", "no strobe while deselected", nvalid, v0);

    // R2: aborted frame, then a full one
    tx_word = 8'h5E;
    frame(3, 32'hE000_0000, mr);
    v0 = nvalid;
    frame(W, 32'h9100_0000, mr);
    chk(last_word == 8'h91 && nvalid == v0 + 1, "R2", "frame after abort", last_word, 8'h91);
    chk(mr[7:0] == 8'h5E, "R2", "tx after abort", mr[7:0], 8'h5E);

    // R6: lenient with surplus clocks, mode 1
    cfg_cpha = 1; tx_word = 8'h81;
    v0 = nvalid;
    frame(W + 2, 32'h6680_0000, mr);
    chk(mr[9:0] == {8'h81, 2'b11}, "R6", "held last bit", mr[9:0], {8'h81, 2'b11});
    chk(last_word == 8'h66 && nvalid == v0 + 1, "R6", "single strobe", nvalid - v0, 1);

    // R7: strict mode
    cfg_strict = 1; cfg_cpha = 0; tx_word = 8'h42;
    v0 = nvalid; e0 = nerr;
    frame(W, 32'hC300_0000, mr);
    chk(last_word == 8'hC3 && nvalid == v0 + 1 && nerr == e0, "R7", "exact frame", last_word, 8'hC3);
    v0 = nvalid;
    frame(W + 1, 32'h1234_0000, mr);
    chk(nvalid == v0 && nerr == e0 + 1, "R7", "long frame rejected", nerr - e0, 1);
    frame(5, 32'hF800_0000, mr);
    chk(nvalid == v0 && nerr == e0 + 1, "R7", "short frame silent", nvalid - v0, 0);

    // R5: chain mode, two words, both phases
    cfg_strict = 1; cfg_chain = 1;
    for (int p = 0; p < 2; p++) begin
      cfg_cpha = p[0]; cfg_cpol = p[0]; tx_word = 8'h7B;
      v0 = nvalid;
      frame(2 * W, 32'hD24B_0000, mr);
      chk(mr[15:0] == {8'h7B, 8'hD2}, "R5", "chain pass-through", mr[15:0], {8'h7B, 8'hD2});
      chk(nvalid == v0 + 2 && last_word == 8'h4B, "R5", "strobe per word", nvalid - v0, 2);
    end

    cyc(10);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule